// File: doc/BRIEF.md
# Kill-Propagate Comparator and Running AND/OR Unit

This purely combinational unit derives three related results from a single ripple chain. The chain starts with its carry asserted. At each bit position a per-bit propagate term either passes the carry upward or forces it low. In equality mode the propagate term says whether the two operand bits match. The surviving carry at the top is then the equal flag, and the carry seen at each position is a running "matched so far" vector. In running-AND mode the propagate term is the input bit itself, so each output bit is the AND of all input bits at or below it. Running-OR mode reuses the same chain on the complemented input and complements the result.

The chain is written as an increment: a one is added to the zero-extended propagate vector, and the sum is XORed with that vector to recover the carry at each position. No reduction tree and no vendor primitive is involved, so any synthesis tool can map the chain onto its own fast carry logic. Operand width is a parameter. Width 1 is supported.

Top module: `carry_cmp_prefix`

## Requirements
- R1: With mode_i equal to 2'b00, eq_o is 1 exactly when a_i equals b_i in every bit, and ne_o is always the inverse of eq_o.
- R2: With mode_i equal to 2'b00, prefix_o bit i is 1 exactly when bits i down to 0 of a_i and b_i all match.
- R3: With mode_i equal to 2'b01, prefix_o bit i is the AND of a_i bits i down to 0, and b_i has no effect on any output.
- R4: In running-AND mode, prefix_o is always a contiguous run of ones starting at bit 0. The lowest 0 in a_i clears that bit and every higher output bit, and prefix_o bit 0 equals a_i bit 0.
- R5: With mode_i equal to 2'b10, prefix_o bit i is the OR of a_i bits i down to 0. The lowest 1 in a_i sets that bit and every higher output bit, and b_i has no effect on any output.
- R6: In both running modes (2'b01 and 2'b10), eq_o and ne_o are both 0.
- R7: mode_i equal to 2'b11 gives outputs identical to mode 2'b00 for the same operands.
- R8: With WIDTH = 1, equality reduces to an XNOR of the single operand bits, and both running modes return a_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A, and the input vector of the running modes |
| b_i | input | WIDTH | Operand B, used only in equality mode |
| mode_i | input | 2 | 00 equality, 01 running AND, 10 running OR, 11 equality |
| eq_o | output | 1 | Operands equal (equality modes only) |
| ne_o | output | 1 | Operands differ (equality modes only) |
| prefix_o | output | WIDTH | Per-position chain result, formatted for the selected mode |

## Verification
The bench builds four copies of the unit, at WIDTH 1, 4, 8 and 32. The 1-bit copy covers the degenerate chain in which the increment carry is the only carry. The 4- and 8-bit copies are driven exhaustively over every operand pair that matters, so every kill position and every run length of ones and zeros occurs. The 32-bit copy gets directed edge cases, such as a single mismatch at the least or most significant bit and b_i sweeps in the running modes, plus several thousand random vectors in each mode.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    MODE_EQ     = 2'b00,
    MODE_AND    = 2'b01,
    MODE_OR     = 2'b10,
    MODE_EQ_ALT = 2'b11
  } cc_mode_e;

  // propagate term of one chain position
  function automatic logic prop_bit(cc_mode_e m, logic a, logic b);
    case (m)
      MODE_AND: return a;
      MODE_OR:  return ~a;
      default:  return ~(a ^ b);
    endcase
  endfunction

  function automatic logic is_cmp(cc_mode_e m);
    return (m == MODE_EQ) || (m == MODE_EQ_ALT);
  endfunction
endpackage

// File: rtl/cc_prop_sel.sv
module cc_prop_sel
  import cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  cc_mode_e         mode_i,
  output logic [WIDTH-1:0] prop_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign prop_o[i] = prop_bit(mode_i, a_i[i], b_i[i]);
  end
endmodule

// File: rtl/cc_kp_chain.sv
module cc_kp_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] prop_i,
  output logic [WIDTH-1:0] carry_o
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] prop_ext;
  logic [EXT_W-1:0] sum;

  assign prop_ext = {1'b0, prop_i};
  // +1 injects the asserted carry-in; the adder's carry path is the chain
  assign sum      = prop_ext + EXT_W'(1);
  // carry out of bit i = carry into bit i+1 = sum[i+1] ^ prop_ext[i+1]
  assign carry_o  = sum[EXT_W-1:1] ^ prop_ext[EXT_W-1:1];
endmodule

// File: rtl/cc_out_fmt.sv
module cc_out_fmt
  import cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  cc_mode_e         mode_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic             eq_o,
  output logic             ne_o,
  output logic [WIDTH-1:0] prefix_o
);
  logic cmp;
  logic top;

  assign cmp      = is_cmp(mode_i);
  assign top      = carry_i[WIDTH-1];
  assign eq_o     = cmp & top;
  assign ne_o     = cmp & ~top;
  assign prefix_o = (mode_i == MODE_OR) ? ~carry_i : carry_i;
endmodule

// File: rtl/carry_cmp_prefix.sv
module carry_cmp_prefix
  import cc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       mode_i,
  output logic             eq_o,
  output logic             ne_o,
  output logic [WIDTH-1:0] prefix_o
);
  cc_mode_e         mode;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] carry;

  assign mode = cc_mode_e'(mode_i);

  cc_prop_sel #(.WIDTH(WIDTH)) i_prop_sel (
    .a_i    (a_i),
    .b_i    (b_i),
    .mode_i (mode),
    .prop_o (prop)
  );

  cc_kp_chain #(.WIDTH(WIDTH)) i_chain (
    .prop_i  (prop),
    .carry_o (carry)
  );

  cc_out_fmt #(.WIDTH(WIDTH)) i_out_fmt (
    .mode_i   (mode),
    .carry_i  (carry),
    .eq_o     (eq_o),
    .ne_o     (ne_o),
    .prefix_o (prefix_o)
  );
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       mode_i,
  input logic             eq_o,
  input logic             ne_o,
  input logic [WIDTH-1:0] prefix_o
);
  logic [WIDTH-1:0] inv;
  assign inv = ~prefix_o;

  always_comb begin
    if (mode_i == 2'b00 || mode_i == 2'b11) begin
      p_eq_flag_r1: assert (eq_o == (a_i == b_i))
        else $error("eq_o disagrees with operand compare");
      p_flag_excl_r1: assert ($countones({eq_o, ne_o}) == 1)
        else $error("eq_o/ne_o not complementary");
      p_top_match_r2: assert (prefix_o[WIDTH-1] == eq_o)
        else $error("top chain bit disagrees with eq_o");
    end
    if (mode_i == 2'b01) begin
      p_and_run_r4: assert (((prefix_o + WIDTH'(1)) & prefix_o) == '0)
        else $error("running AND not a run of ones from bit 0");
      p_and_lsb_r4: assert (prefix_o[0] == a_i[0])
        else $error("running AND bit 0 differs from input");
    end
    if (mode_i == 2'b10) begin
      p_or_run_r5: assert (((inv + WIDTH'(1)) & inv) == '0)
        else $error("running OR not a run of zeros from bit 0");
    end
    if (mode_i == 2'b01 || mode_i == 2'b10) begin
      p_flags_low_r6: assert (!eq_o && !ne_o)
        else $error("compare flags raised in running mode");
    end
  end
endmodule

bind carry_cmp_prefix cc_checker #(.WIDTH(WIDTH)) i_cc_checker (
  .a_i      (a_i),
  .b_i      (b_i),
  .mode_i   (mode_i),
  .eq_o     (eq_o),
  .ne_o     (ne_o),
  .prefix_o (prefix_o)
);

// File: tb/test_carry_cmp_prefix.sv
module test_carry_cmp_prefix;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic [0:0]  a1 = '0, b1 = '0, p1;
  logic [3:0]  a4 = '0, b4 = '0, p4;
  logic [7:0]  a8 = '0, b8 = '0, p8;
  logic [31:0] a32 = '0, b32 = '0, p32;
  logic [1:0]  m1 = '0, m4 = '0, m8 = '0, m32 = '0;
  logic eq1, ne1, eq4, ne4, eq8, ne8, eq32, ne32;

  carry_cmp_prefix #(.WIDTH(1)) i_carry_cmp_prefix_w1 (
    .a_i(a1), .b_i(b1), .mode_i(m1), .eq_o(eq1), .ne_o(ne1), .prefix_o(p1));
  carry_cmp_prefix #(.WIDTH(4)) i_carry_cmp_prefix_w4 (
    .a_i(a4), .b_i(b4), .mode_i(m4), .eq_o(eq4), .ne_o(ne4), .prefix_o(p4));
  carry_cmp_prefix #(.WIDTH(8)) i_carry_cmp_prefix_w8 (
    .a_i(a8), .b_i(b8), .mode_i(m8), .eq_o(eq8), .ne_o(ne8), .prefix_o(p8));
  carry_cmp_prefix #(.WIDTH(32)) i_carry_cmp_prefix (
    .a_i(a32), .b_i(b32), .mode_i(m32), .eq_o(eq32), .ne_o(ne32), .prefix_o(p32));

  function automatic string req_of(logic [1:0] m);
    case (m)
      2'b00:   return "R1/R2";
      2'b01:   return "R3/R4/R6";
      2'b10:   return "R5/R6";
      default: return "R7";
    endcase
  endfunction

  // reference: drive one instance, wait, compare against a bitwise scan
  task automatic apply(input int w, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] m, input string req);
    logic [31:0] got_p, exp_p;
    logic got_eq, got_ne, exp_eq, exp_ne;
    logic run_eq, run_and, run_or, cmp;
    case (w)
      1:  begin a1 = a[0:0];  b1 = b[0:0];  m1 = m;  end
      4:  begin a4 = a[3:0];  b4 = b[3:0];  m4 = m;  end
      8:  begin a8 = a[7:0];  b8 = b[7:0];  m8 = m;  end
      default: begin a32 = a; b32 = b;      m32 = m; end
    endcase
    #1;
    case (w)
      1:  begin got_p = {31'b0, p1}; got_eq = eq1; got_ne = ne1; end
      4:  begin got_p = {28'b0, p4}; got_eq = eq4; got_ne = ne4; end
      8:  begin got_p = {24'b0, p8}; got_eq = eq8; got_ne = ne8; end
      default: begin got_p = p32;    got_eq = eq32; got_ne = ne32; end
    endcase
    exp_p = '0;
    run_eq = 1'b1; run_and = 1'b1; run_or = 1'b0;
    for (int i = 0; i < w; i++) begin
      run_eq  = run_eq && (a[i] == b[i]);
      run_and = run_and && a[i];
      run_or  = run_or || a[i];
      case (m)
        2'b01:   exp_p[i] = run_and;
        2'b10:   exp_p[i] = run_or;
        default: exp_p[i] = run_eq;
      endcase
    end
    cmp    = (m == 2'b00) || (m == 2'b11);
    exp_eq = cmp && run_eq;
    exp_ne = cmp && !run_eq;
    n_chk++;
    if (got_p !== exp_p || got_eq !== exp_eq || got_ne !== exp_ne) begin
      n_fail++;
      $display("FAIL %s w=%0d mode=%b a=%h b=%h: got p=%h eq=%b ne=%b, exp p=%h eq=%b ne=%b",
               req, w, m, a, b, got_p, got_eq, got_ne, exp_p, exp_eq, exp_ne);
    end
  endtask

  task automatic t_idle_state;  // R1 R2: zero operands compare equal
    apply(32, 32'h0, 32'h0, 2'b00, "R1/R2 idle");
  endtask

  task automatic t_width1;  // R8
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          apply(1, 32'(a), 32'(b), 2'(m), "R8");
  endtask

  task automatic t_exh4;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(4, 32'(a), 32'(b), 2'(m), req_of(2'(m)));
  endtask

  task automatic t_exh8;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(8, 32'(a), 32'(b), 2'b00, "R1/R2");
    for (int a = 0; a < 256; a++) begin
      apply(8, 32'(a), 32'(255 - a), 2'b01, "R3/R4/R6");
      apply(8, 32'(a), 32'(a), 2'b10, "R5/R6");
      apply(8, 32'(a), 32'(a ^ 8'h10), 2'b11, "R7");
    end
  endtask

  task automatic t_edges32;
    apply(32, 32'hdead_beef, 32'hdead_beef, 2'b00, "R1 equal");
    apply(32, 32'hdead_beef, 32'hdead_beee, 2'b00, "R1/R2 lsb kill");
    apply(32, 32'h5555_5555, 32'hd555_5555, 2'b00, "R1/R2 msb kill");
    apply(32, 32'h5555_5555, 32'hd555_5555, 2'b11, "R7 msb kill");
    apply(32, 32'hffff_ffff, 32'h0, 2'b01, "R3 all ones");
    apply(32, 32'hffff_7fff, 32'h0, 2'b01, "R4 mid zero");
    apply(32, 32'h0, 32'hffff_ffff, 2'b10, "R5 all zeros");
    apply(32, 32'h8000_0000, 32'h0, 2'b10, "R5 msb one");
  endtask

  task automatic t_ignore_b;  // R3 R5: b_i sweeps, prefix unchanged
    for (int k = 0; k < 32; k++) begin
      apply(32, 32'h00ff_f0ff, 32'h1 << k, 2'b01, "R3 b ignored");
      apply(32, 32'h0000_0100, ~(32'h1 << k), 2'b10, "R5 b ignored");
    end
  endtask

  task automatic t_rand32;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (n % 3 == 0) ? a ^ (32'h1 << (n % 32)) : $urandom;
      for (int m = 0; m < 4; m++)
        apply(32, a, b, 2'(m), req_of(2'(m)));
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_idle_state();
    t_width1();
    t_exh4();
    t_exh8();
    t_edges32();
    t_ignore_b();
    t_rand32();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule